// File: doc/BRIEF.md
# Drawing-Engine Register Write Queue

This block sits between a host bus and a 2D drawing engine. Every 16-bit register write from the host is pushed into a small in-order queue. Entries leave the queue one at a time and update a set of parameter registers held for the engine:

- source and destination coordinates
- rectangle width and height, each written as the count minus one
- the foreground mix
- a pixel control field
- the operation word

Height and pixel control are not written directly. They arrive through one shared multifunction address, where the top four bits of the word pick the target and the low twelve bits carry its value. When an operation word reaches the head of the queue, it is held there until the engine is idle. It is then loaded and the engine receives a one-cycle start pulse.

Software polls a status mask before writing. The mask has one bit per queue slot and is filled as a thermometer code, so an all-zero mask means the queue has drained. A write that arrives while all slots are taken is thrown away and sets a sticky overflow flag. A single busy output summarises the front end: it is high while the queue holds entries, while a start is in flight, or while the engine reports work.

Top module: `cfq_front`

## Requirements
- R1: After reset, the status mask, the overflow flag, the busy output, the start pulse and every parameter register read zero. A pixel control of zero means unpacked source data with the foreground mix in use.
- R2: A write is accepted while fewer than DEPTH (8) entries are queued. Bit i of the status mask (bit 0 is the least significant bit) is 1 exactly when more than i entries are queued.
- R3: A write presented while the queue holds DEPTH entries is discarded. Its data never reaches any register, and the overflow flag goes to 1 and stays at 1 until reset.
- R4: Entries are applied in the order they were written, one per clock. An entry written into an otherwise empty queue updates its register at the second rising edge after the write is presented.
- R5: Address decode on the 3-bit select: 0 sets source X, 1 sets source Y, 2 sets destination X, 3 sets destination Y, 4 sets width-minus-one, 5 sets the foreground mix, 6 is the multifunction register and 7 is the operation word.
- R6: For a multifunction write, data bits 15..12 are an index and bits 11..0 are the value. Index 0x0 loads height-minus-one, index 0xA loads pixel control, and any other index changes no register.
- R7: An operation word at the head of the queue is popped only when the engine is not busy and no start pulse is in flight. When it is popped, it loads the operation register and raises the start output for exactly one cycle, the cycle after the pop.
- R8: Parameter entries at the head of the queue are applied even while the engine is busy.
- R9: The busy output is 1 while the queue is non-empty, while a start pulse is out, or while the engine busy input is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 16 | Write data |
| occ_mask | output | DEPTH | Queue fill as a thermometer mask |
| overflow | output | 1 | Sticky flag: a write was dropped |
| busy | output | 1 | Queue, start or engine still active |
| eng_busy | input | 1 | Engine reports an operation in progress |
| eng_start | output | 1 | One-cycle pulse launching the engine |
| cmd_word | output | 16 | Last operation word applied |
| src_x | output | 16 | Source X |
| src_y | output | 16 | Source Y |
| dst_x | output | 16 | Destination X |
| dst_y | output | 16 | Destination Y |
| width_m1 | output | 16 | Width minus one |
| height_m1 | output | 12 | Height minus one |
| fg_mix | output | 16 | Foreground mix |
| pix_ctrl | output | 12 | Pixel control |

## Verification
The start-pulse properties assume that the engine raises its busy input in the cycle after it sees a start, and keeps it high until the operation finishes. The bench's engine model does exactly this, with a programmable run length. Nothing is assumed about the write strobe: writes may arrive back to back and into a full queue. The bench holds the engine busy on purpose to pile entries up behind an operation word, so that it can drive the queue to full and past it. All stimulus is applied at the falling clock edge.

// File: rtl/cfq_pkg.sv
package cfq_pkg;
    localparam int DATA_W     = 16;
    localparam int SEL_W      = 3;
    localparam int SUB_IDX_W  = 4;
    localparam int SUB_VAL_W  = DATA_W - SUB_IDX_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_SRC_X = 3'd0,
        SEL_SRC_Y = 3'd1,
        SEL_DST_X = 3'd2,
        SEL_DST_Y = 3'd3,
        SEL_WIDTH = 3'd4,
        SEL_MIX   = 3'd5,
        SEL_MULTI = 3'd6,
        SEL_CMD   = 3'd7
    } reg_sel_e;

    localparam logic [SUB_IDX_W-1:0] SUB_HEIGHT = 4'h0;
    localparam logic [SUB_IDX_W-1:0] SUB_PIXCTL = 4'hA;

    typedef struct packed {
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } entry_t;

    function automatic logic [SUB_IDX_W-1:0] sub_index(input logic [DATA_W-1:0] w);
        return w[DATA_W-1 -: SUB_IDX_W];
    endfunction

    function automatic logic [SUB_VAL_W-1:0] sub_value(input logic [DATA_W-1:0] w);
        return w[SUB_VAL_W-1:0];
    endfunction
endpackage

// File: rtl/cfq_fifo.sv
module cfq_fifo
    import cfq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  entry_t                       push_ent,
    input  logic                         pop,
    output entry_t                       head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    entry_t             mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic               full, accept, take;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign full   = (count == CNT_FULL);
    assign accept = push && !full;
    assign take   = pop && (count != '0);
    assign head   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (accept) wr_ptr <= bump(wr_ptr);
            if (take)   rd_ptr <= bump(rd_ptr);
            case ({accept, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && full) overflow <= 1'b1;
        end
    end

    // R2: occupancy never exceeds the slot count
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_FULL);
    // R3: overflow flag is sticky
    a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    // R3: a write into a full queue does not grow it
    a_r3_drop_when_full: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == CNT_FULL) && overflow);
endmodule

// File: rtl/cfq_regs.sv
module cfq_regs
    import cfq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  entry_t                head,
    input  logic                  has_entry,
    input  logic                  eng_busy,
    output logic                  pop,
    output logic                  eng_start,
    output logic [DATA_W-1:0]     cmd_word,
    output logic [DATA_W-1:0]     src_x,
    output logic [DATA_W-1:0]     src_y,
    output logic [DATA_W-1:0]     dst_x,
    output logic [DATA_W-1:0]     dst_y,
    output logic [DATA_W-1:0]     width_m1,
    output logic [SUB_VAL_W-1:0]  height_m1,
    output logic [DATA_W-1:0]     fg_mix,
    output logic [SUB_VAL_W-1:0]  pix_ctrl
);
    logic                  head_is_cmd;
    logic [SUB_IDX_W-1:0]  idx;
    logic [SUB_VAL_W-1:0]  val;

    assign head_is_cmd = (head.sel == SEL_CMD);
    assign idx         = sub_index(head.data);
    assign val         = sub_value(head.data);
    // operation words wait for an idle engine and no start in flight
    assign pop = has_entry && (!head_is_cmd || (!eng_busy && !eng_start));

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_start <= 1'b0;
            cmd_word  <= '0;
            src_x     <= '0;
            src_y     <= '0;
            dst_x     <= '0;
            dst_y     <= '0;
            width_m1  <= '0;
            height_m1 <= '0;
            fg_mix    <= '0;
            pix_ctrl  <= '0;
        end else begin
            eng_start <= 1'b0;
            if (pop) begin
                unique case (head.sel)
                    SEL_SRC_X: src_x    <= head.data;
                    SEL_SRC_Y: src_y    <= head.data;
                    SEL_DST_X: dst_x    <= head.data;
                    SEL_DST_Y: dst_y    <= head.data;
                    SEL_WIDTH: width_m1 <= head.data;
                    SEL_MIX:   fg_mix   <= head.data;
                    SEL_MULTI: begin
                        if (idx == SUB_HEIGHT) height_m1 <= val;
                        if (idx == SUB_PIXCTL) pix_ctrl  <= val;
                    end
                    SEL_CMD: begin
                        cmd_word  <= head.data;
                        eng_start <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7: the start output is a single-cycle pulse
    a_r7_start_single: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);
    // R7: a start follows only a pop made while the engine was idle
    a_r7_start_when_idle: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !$past(eng_busy));
    // R6: unknown multifunction indexes leave height and pixel control alone
    a_r6_other_index_ignored: assert property (@(posedge clk) disable iff (rst)
        (pop && head.sel == SEL_MULTI && idx != SUB_HEIGHT && idx != SUB_PIXCTL)
        |=> ($stable(height_m1) && $stable(pix_ctrl)));
endmodule

// File: rtl/cfq_front.sv
module cfq_front
    import cfq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [2:0]            wr_sel,
    input  logic [15:0]           wr_data,
    output logic [DEPTH-1:0]      occ_mask,
    output logic                  overflow,
    output logic                  busy,
    input  logic                  eng_busy,
    output logic                  eng_start,
    output logic [15:0]           cmd_word,
    output logic [15:0]           src_x,
    output logic [15:0]           src_y,
    output logic [15:0]           dst_x,
    output logic [15:0]           dst_y,
    output logic [15:0]           width_m1,
    output logic [11:0]           height_m1,
    output logic [15:0]           fg_mix,
    output logic [11:0]           pix_ctrl
);
    localparam int CNT_W = $clog2(DEPTH+1);

    entry_t            in_ent, head;
    logic [CNT_W-1:0]  count;
    logic              pop;

    assign in_ent.sel  = reg_sel_e'(wr_sel);
    assign in_ent.data = wr_data;

    cfq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (wr_en),
        .push_ent (in_ent),
        .pop      (pop),
        .head     (head),
        .count    (count),
        .overflow (overflow)
    );

    cfq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .head      (head),
        .has_entry (count != '0),
        .eng_busy  (eng_busy),
        .pop       (pop),
        .eng_start (eng_start),
        .cmd_word  (cmd_word),
        .src_x     (src_x),
        .src_y     (src_y),
        .dst_x     (dst_x),
        .dst_y     (dst_y),
        .width_m1  (width_m1),
        .height_m1 (height_m1),
        .fg_mix    (fg_mix),
        .pix_ctrl  (pix_ctrl)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_therm
        assign occ_mask[g] = (count > CNT_W'(g));
    end

    assign busy = (count != '0) || eng_start || eng_busy;

    // R2: the mask carries one set bit per queued entry
    a_r2_mask_matches: assert property (@(posedge clk) disable iff (rst)
        $countones(occ_mask) == count);
    // R9: engine activity is always visible on busy
    a_r9_busy_engine: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> busy);
    // R9: a start pulse is covered by busy
    a_r9_busy_start: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> busy);
endmodule

// File: tb/cfq_front_tb.sv
module cfq_front_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [DEPTH-1:0] occ_mask;
    logic overflow, busy, eng_busy, eng_start;
    logic [15:0] cmd_word, src_x, src_y, dst_x, dst_y, width_m1, fg_mix;
    logic [11:0] height_m1, pix_ctrl;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // engine model
    logic hold_busy = 1'b0;
    logic m_busy;
    int m_cnt;
    int eng_len = 4;
    int n_start;
    int overlap;
    logic [15:0] cap_cmd [4];
    logic [15:0] cap_dst [4];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign eng_busy = m_busy | hold_busy;

    cfq_front #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .occ_mask(occ_mask), .overflow(overflow), .busy(busy),
        .eng_busy(eng_busy), .eng_start(eng_start), .cmd_word(cmd_word),
        .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
        .width_m1(width_m1), .height_m1(height_m1), .fg_mix(fg_mix),
        .pix_ctrl(pix_ctrl)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_busy  <= 1'b0;
            m_cnt   <= 0;
            n_start <= 0;
            overlap <= 0;
        end else if (eng_start) begin
            if (eng_busy) overlap <= overlap + 1;
            cap_cmd[n_start & 3] <= cmd_word;
            cap_dst[n_start & 3] <= dst_x;
            n_start <= n_start + 1;
            m_busy  <= 1'b1;
            m_cnt   <= eng_len;
        end else if (m_busy) begin
            if (m_cnt <= 1) m_busy <= 1'b0;
            m_cnt <= m_cnt - 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && occ_mask != '0; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1 mask", occ_mask, 0);
        chk_eq("R1 overflow", overflow, 0);
        chk_eq("R1 busy", busy, 0);
        chk_eq("R1 start", eng_start, 0);
        chk_eq("R1 regs", {src_x, dst_y, width_m1, fg_mix}, 0);
        chk_eq("R1 pixctl", pix_ctrl, 0);
    endtask

    task automatic t_decode();
        wr(3'd0, 16'h0011);
        wr(3'd1, 16'h0022);
        wr(3'd2, 16'h0033);
        wr(3'd3, 16'h0044);
        wr(3'd4, 16'h0055);
        wr(3'd5, 16'h0067);
        drain();
        chk_eq("R5 src_x", src_x, 16'h0011);
        chk_eq("R5 src_y", src_y, 16'h0022);
        chk_eq("R5 dst_x", dst_x, 16'h0033);
        chk_eq("R5 dst_y", dst_y, 16'h0044);
        chk_eq("R5 width", width_m1, 16'h0055);
        chk_eq("R5 mix", fg_mix, 16'h0067);
        chk_eq("R5 no start", n_start, 0);
    endtask

    task automatic t_multi();
        wr(3'd6, 16'hA123);
        wr(3'd6, 16'h0007);
        drain();
        chk_eq("R6 pixctl", pix_ctrl, 12'h123);
        chk_eq("R6 height", height_m1, 12'h007);
        wr(3'd6, 16'h5ABC);
        wr(3'd6, 16'hFFFF);
        drain();
        chk_eq("R6 other idx height", height_m1, 12'h007);
        chk_eq("R6 other idx pixctl", pix_ctrl, 12'h123);
        chk_eq("R6 other idx regs", {src_x, width_m1}, {16'h0011, 16'h0055});
    endtask

    task automatic t_order();
        wr(3'd1, 16'h00A1);
        chk_eq("R4 not yet applied", src_y, 16'h0022);
        wr(3'd1, 16'h00A2);
        chk_eq("R4 first applied", src_y, 16'h00A1);
        wr(3'd1, 16'h00A3);
        chk_eq("R4 second applied", src_y, 16'h00A2);
        chk_eq("R4 mask one", occ_mask, 8'h01);
        @(negedge clk);
        chk_eq("R4 last applied", src_y, 16'h00A3);
    endtask

    task automatic t_busy();
        chk_eq("R9 idle", busy, 0);
        wr(3'd5, 16'h0066);
        chk_eq("R9 queued", busy, 1);
        @(negedge clk);
        chk_eq("R9 drained", busy, 0);
    endtask

    task automatic t_fill();
        wait_idle();
        hold_busy = 1'b1;
        wr(3'd7, 16'h1111);
        wr(3'd0, 16'h0100);
        wr(3'd0, 16'h0101);
        chk_eq("R2 three entries", occ_mask, 8'h07);
        for (int i = 2; i < 7; i++) wr(3'd0, 16'h0100 + 16'(i));
        chk_eq("R2 full mask", occ_mask, 8'hFF);
        chk_eq("R7 blocked by busy", n_start, 0);
        chk_eq("R3 no overflow yet", overflow, 0);
        wr(3'd0, 16'hDEAD);
        chk_eq("R3 overflow", overflow, 1);
        chk_eq("R3 mask stays full", occ_mask, 8'hFF);
        chk_eq("R3 src untouched", src_x, 16'h0011);
        eng_len = 30;
        hold_busy = 1'b0;
        drain();
        chk_eq("R7 one start", n_start, 1);
        chk_eq("R7 cmd word", cmd_word, 16'h1111);
        chk_eq("R8 engine still busy", m_busy, 1);
        chk_eq("R9 busy on engine", busy, 1);
        chk_eq("R3 dropped write lost", src_x, 16'h0106);
        wait_idle();
        chk_eq("R3 sticky", overflow, 1);
        eng_len = 4;
    endtask

    task automatic t_serial();
        int base;
        wait_idle();
        base = n_start;
        wr(3'd2, 16'h0040);
        wr(3'd7, 16'hC013);
        wr(3'd2, 16'h0080);
        wr(3'd7, 16'hC0F3);
        for (int i = 0; i < 200 && n_start < base + 2; i++) @(negedge clk);
        wait_idle();
        chk_eq("R7 two starts", n_start - base, 2);
        chk_eq("R7 no overlap", overlap, 0);
        chk_eq("R7 first cmd", cap_cmd[base & 3], 16'hC013);
        chk_eq("R7 first dst", cap_dst[base & 3], 16'h0040);
        chk_eq("R7 second cmd", cap_cmd[(base + 1) & 3], 16'hC0F3);
        chk_eq("R7 second dst", cap_dst[(base + 1) & 3], 16'h0080);
    endtask

    task automatic t_reset_clears();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R3 cleared by reset", overflow, 0);
        chk_eq("R1 cmd after reset", cmd_word, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_decode();
        t_multi();
        t_order();
        t_busy();
        t_fill();
        t_serial();
        t_reset_clears();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule